// File: doc/BRIEF.md
# Bit activity profiling monitor

This block observes a parallel data bus, for example the write or read data path of a cache array, for a programmable number of clock cycles. For every bus bit it counts the cycles in which that bit was high and the number of times it changed value between consecutive samples. These counts are the raw activity measures used by wear-out analysis: how long a storage node is held in one state and how often it switches.

When the observation window closes, the block reduces each count to a stress bin between 0 and 20, one bin per 5 percent. The high-time count is binned against the window length. The toggle count is binned against the largest toggle count seen on any bit in the same window. A simple combinational read port, indexed by bit number, returns both bins of the selected bit. A start pulse clears the counters and opens a new window. A done flag reports that every bin has been written.

Top module: `bit_activity_monitor`

## Requirements
- R1: After reset `done` and `busy` are 0 and both bins read 0 for every bit index.
- R2: A `start` pulse latches `win_len` and clears all counters. The window then takes exactly `win_len` samples of `data_in`, one per cycle, starting at the edge after `start`. A `win_len` of 0 is treated as 1. `busy` is 1 from the edge that takes `start` until `done` rises.
- R3: The duty bin of a bit is round-half-up(20 × H / L), where H is the number of samples in which the bit was 1 and L is the window length. It is 0 when the bit was never 1 and 20 when the bit was 1 in every sample.
- R4: A toggle is counted when a bit differs from its value in the previous sample of the same window, in either direction. The first sample of a window is never compared with anything, including values seen before `start`.
- R5: The toggle bin of a bit is round-half-up(20 × T / M), where T is its toggle count and M is the largest T over all bits in the window. A bit whose count equals M reads 20.
- R6: If no bit toggled during the window (M = 0), every toggle bin reads 0.
- R7: `done` rises exactly L + 2 × BUS_W cycles after the edge that takes `start`. It stays 1 and the bins stay unchanged until the next `start`.
- R8: A `start` during a running window restarts the window. The partial counts are discarded, and the results reflect only the new window.
- R9: `rd_duty_bin` and `rd_tog_bin` are bits [4:0] of the bins of the bit selected by `rd_idx`, and they follow `rd_idx` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that opens a new observation window |
| win_len | input | CNT_W | Window length in samples, latched at start |
| data_in | input | BUS_W | Monitored bus, sampled every cycle of the window |
| busy | output | 1 | Window or binning in progress |
| done | output | 1 | All bins of the last window are valid |
| rd_idx | input | IDX_W | Bit number to read |
| rd_duty_bin | output | 5 | Duty bin (0 to 20) of the selected bit |
| rd_tog_bin | output | 5 | Toggle bin (0 to 20) of the selected bit |

## Verification
On every cycle, the in-RTL assertions check the following. No bit's high-time count exceeds the number of samples taken. No toggle is counted before a second sample exists. A bit held high for the whole window always quantizes to bin 20, and the bit carrying the maximum toggle count quantizes to 20. A zero maximum forces toggle bin 0. A start always empties the sample count. The results seen on the read port hold while `done` stays high. Only the bench scenarios can show the exact bin value of every bit under counting, hashed and static patterns over a sweep of window lengths. They also show the precise cycle at which `done` rises, the treatment of a zero window length, and that a restart discards the partial counts.

// File: rtl/bam_pkg.sv
package bam_pkg;
   localparam int NSTEP = 20;
   localparam int BIN_W = 5;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COLLECT,
      ST_SCAN,
      ST_BIN,
      ST_DONE
   } bam_state_t;
endpackage

// File: rtl/bam_bit_counter.sv
module bam_bit_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             first,
   input  logic             d,
   output logic [CNT_W-1:0] ones_o,
   output logic [CNT_W-1:0] tog_o
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         ones_o <= '0;
         tog_o  <= '0;
      end else if (clr) begin
         ones_o <= '0;
         tog_o  <= '0;
      end else if (en) begin
         prev_q <= d;
         if (d && ones_o != CMAX) ones_o <= ones_o + 1'b1;
         if (!first && (d ^ prev_q) && tog_o != CMAX) tog_o <= tog_o + 1'b1;
      end
   end
endmodule

// File: rtl/bam_quantizer.sv
module bam_quantizer
   import bam_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit USE_DIV = 1'b0
) (
   input  logic [CNT_W-1:0] num,
   input  logic [CNT_W-1:0] ref_val,
   output logic [BIN_W-1:0] bin
);
   localparam int W = CNT_W + 7;

   logic [W-1:0] n40;
   logic [W-1:0] r_ext;

   assign r_ext = W'(ref_val);
   assign n40   = W'(num) * W'(2 * NSTEP);

   generate
      if (USE_DIV) begin : g_div
         logic [W-1:0] quo;
         always_comb begin
            if (ref_val == '0) quo = '0;
            else               quo = (n40 + r_ext) / (r_ext << 1);
         end
         assign bin = BIN_W'(quo);
      end else begin : g_cmp
         logic [NSTEP-1:0] ge;
         for (genvar k = 1; k <= NSTEP; k++) begin : g_step
            assign ge[k-1] = (ref_val != '0) && (n40 >= W'(2 * k - 1) * r_ext);
         end
         assign bin = BIN_W'($countones(ge));
      end
   endgenerate
endmodule

// File: rtl/bit_activity_monitor.sv
module bit_activity_monitor
   import bam_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int CNT_W   = 16,
   parameter bit USE_DIV = 1'b0,
   localparam int IDX_W  = (BUS_W > 1) ? $clog2(BUS_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] win_len,
   input  logic [BUS_W-1:0] data_in,
   output logic             busy,
   output logic             done,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [BIN_W-1:0] rd_duty_bin,
   output logic [BIN_W-1:0] rd_tog_bin
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(BUS_W - 1);

   generate
      if (BUS_W < 1) begin : g_bad_bus
         $error("BUS_W must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 2..32");
      end
   endgenerate

   bam_state_t       st;
   logic [CNT_W-1:0] win_q;
   logic [CNT_W-1:0] samp_q;
   logic [CNT_W-1:0] tmax_q;
   logic [IDX_W-1:0] ptr_q;

   logic [CNT_W-1:0] ones [BUS_W];
   logic [CNT_W-1:0] tog  [BUS_W];
   logic [BIN_W-1:0] dbin [BUS_W];
   logic [BIN_W-1:0] tbin [BUS_W];

   logic             cnt_en;
   logic             first_s;
   logic [BIN_W-1:0] q_duty;
   logic [BIN_W-1:0] q_tog;

   assign cnt_en  = (st == ST_COLLECT);
   assign first_s = (samp_q == '0);

   for (genvar i = 0; i < BUS_W; i++) begin : g_bit
      bam_bit_counter #(.CNT_W(CNT_W)) cnt_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (start),
         .en     (cnt_en),
         .first  (first_s),
         .d      (data_in[i]),
         .ones_o (ones[i]),
         .tog_o  (tog[i])
      );

      // R3: high-time never exceeds samples taken so far
      assert_ones_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (st == ST_COLLECT) |-> (ones[i] <= samp_q));
      // R4: no toggle before two samples exist
      assert_tog_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (st == ST_COLLECT && samp_q <= CNT_W'(1)) |-> (tog[i] == '0));
   end

   bam_quantizer #(.CNT_W(CNT_W), .USE_DIV(USE_DIV)) qd_i (
      .num     (ones[ptr_q]),
      .ref_val (win_q),
      .bin     (q_duty)
   );

   bam_quantizer #(.CNT_W(CNT_W), .USE_DIV(USE_DIV)) qt_i (
      .num     (tog[ptr_q]),
      .ref_val (tmax_q),
      .bin     (q_tog)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         win_q  <= CNT_W'(1);
         samp_q <= '0;
         tmax_q <= '0;
         ptr_q  <= '0;
      end else if (start) begin
         st     <= ST_COLLECT;
         win_q  <= (win_len == '0) ? CNT_W'(1) : win_len;
         samp_q <= '0;
      end else begin
         case (st)
            ST_COLLECT: begin
               samp_q <= samp_q + 1'b1;
               if (samp_q == win_q - 1'b1) begin
                  st     <= ST_SCAN;
                  ptr_q  <= '0;
                  tmax_q <= '0;
               end
            end
            ST_SCAN: begin
               if (tog[ptr_q] > tmax_q) tmax_q <= tog[ptr_q];
               if (ptr_q == LAST) begin
                  st    <= ST_BIN;
                  ptr_q <= '0;
               end else begin
                  ptr_q <= ptr_q + 1'b1;
               end
            end
            ST_BIN: begin
               if (ptr_q == LAST) st <= ST_DONE;
               else               ptr_q <= ptr_q + 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < BUS_W; b++) begin
            dbin[b] <= '0;
            tbin[b] <= '0;
         end
      end else if (!start && st == ST_BIN) begin
         dbin[ptr_q] <= q_duty;
         tbin[ptr_q] <= q_tog;
      end
   end

   assign busy = (st == ST_COLLECT) || (st == ST_SCAN) || (st == ST_BIN);
   assign done = (st == ST_DONE);

   generate
      if (BUS_W == (1 << IDX_W)) begin : g_rd_full
         assign rd_duty_bin = dbin[rd_idx];
         assign rd_tog_bin  = tbin[rd_idx];
      end else begin : g_rd_guard
         assign rd_duty_bin = (rd_idx < IDX_W'(BUS_W)) ? dbin[rd_idx] : '0;
         assign rd_tog_bin  = (rd_idx < IDX_W'(BUS_W)) ? tbin[rd_idx] : '0;
      end
   endgenerate

   // R3: a bit high for the whole window lands in the top bin
   assert_full_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BIN && ones[ptr_q] == win_q) |-> (q_duty == BIN_W'(NSTEP)));
   // R5: the bit carrying the maximum toggle count lands in the top bin
   assert_max_bin_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BIN && tmax_q != '0 && tog[ptr_q] == tmax_q) |-> (q_tog == BIN_W'(NSTEP)));
   // R6: zero maximum gives toggle bin 0
   assert_zero_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BIN && tmax_q == '0) |-> (q_tog == '0));
   // R7: results hold while done stays high
   assert_hold_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done) && $stable(rd_idx)) |-> ($stable(rd_duty_bin) && $stable(rd_tog_bin)));
   // R8: start always empties the sample count and reopens the window
   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (samp_q == '0 && busy));
endmodule

// File: tb/bit_activity_monitor_tb_top.sv
module bit_activity_monitor_tb_top;
   localparam int BW = 8;
   localparam int CW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] win_len = '0;
   logic [BW-1:0] data_in = '0;
   logic          busy, done;
   logic [2:0]    rd_idx = '0;
   logic [4:0]    rd_duty_bin, rd_tog_bin;

   int checks = 0;
   int fails  = 0;
   int e_duty [BW];
   int e_tog  [BW];

   always #5 clk = ~clk;

   bit_activity_monitor #(.BUS_W(BW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .win_len(win_len),
      .data_in(data_in), .busy(busy), .done(done), .rd_idx(rd_idx),
      .rd_duty_bin(rd_duty_bin), .rd_tog_bin(rd_tog_bin)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [BW-1:0] pat(input int mode, input int j);
      logic [31:0] x;
      case (mode)
         0: pat = '0;
         1: pat = '1;
         2: pat = BW'(j);
         3: begin x = 32'(j * j * 13 + j * 7 + 5); pat = x[8:1]; end
         default: pat = {4'b1010, 3'b000, 1'(j)};
      endcase
   endfunction

   function automatic int qbin(input int c, input int r);
      if (r == 0) return 0;
      return (40 * c + r) / (2 * r);
   endfunction

   task automatic compute(input int mode, input int len);
      int h [BW];
      int t [BW];
      int mx;
      logic [BW-1:0] p, pv;
      pv = '0;
      mx = 0;
      for (int b = 0; b < BW; b++) begin h[b] = 0; t[b] = 0; end
      for (int j = 1; j <= len; j++) begin
         p = pat(mode, j);
         for (int b = 0; b < BW; b++) begin
            h[b] += int'(p[b]);
            if (j > 1) t[b] += int'(p[b] ^ pv[b]);
         end
         pv = p;
      end
      for (int b = 0; b < BW; b++) if (t[b] > mx) mx = t[b];
      for (int b = 0; b < BW; b++) begin
         e_duty[b] = qbin(h[b], len);
         e_tog[b]  = qbin(t[b], mx);
      end
   endtask

   task automatic check_bins(input string tag);
      for (int b = 0; b < BW; b++) begin
         rd_idx = 3'(b);
         #1;
         chk({tag, " R3 R9 duty"}, int'(rd_duty_bin), e_duty[b]);
         chk({tag, " R4 R5 R6 toggle"}, int'(rd_tog_bin), e_tog[b]);
      end
   endtask

   // opens a window at the next edge and feeds pat(mode, j) as sample j
   task automatic open_window(input int wl);
      @(negedge clk);
      win_len = CW'(wl);
      start   = 1'b1;
      data_in = 8'h5A;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_window(input int mode, input int wl);
      int len, n;
      len = (wl == 0) ? 1 : wl;
      open_window(wl);
      data_in = pat(mode, 1);
      chk("R2 busy after start", int'(busy), 1);
      n = 0;
      while (!done && n < 4000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (n < len) data_in = pat(mode, n + 1);
      end
      chk("R7 done latency", n, len + 2 * BW);
      chk("R2 busy clear at done", int'(busy), 0);
      compute(mode, len);
      check_bins("window");
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int lens [6];
      lens = '{1, 2, 5, 20, 37, 100};
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 done", int'(done), 0);
      chk("R1 busy", int'(busy), 0);
      for (int b = 0; b < BW; b++) begin
         rd_idx = 3'(b);
         #1;
         chk("R1 duty", int'(rd_duty_bin), 0);
         chk("R1 toggle", int'(rd_tog_bin), 0);
      end

      // sweep patterns and window lengths (R3 R4 R5 R6 R7)
      for (int m = 0; m < 5; m++)
         for (int k = 0; k < 6; k++)
            run_window(m, lens[k]);

      // R2: zero length behaves as one sample
      run_window(3, 0);

      // R4: window after all-zero history, first sample all ones
      run_window(0, 3);
      run_window(1, 4);

      // R7: hold after done
      repeat (7) @(negedge clk);
      chk("R7 done held", int'(done), 1);
      check_bins("R7 hold");

      // R8: restart during a running window
      begin
         int n;
         open_window(50);
         for (int j = 1; j <= 10; j++) begin
            data_in = 8'hFF;
            @(posedge clk);
            @(negedge clk);
         end
         open_window(20);
         data_in = pat(2, 1);
         n = 0;
         while (!done && n < 4000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n < 20) data_in = pat(2, n + 1);
         end
         chk("R8 restart latency", n, 20 + 2 * BW);
         compute(2, 20);
         check_bins("R8 restart");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule